// File: doc/BRIEF.md
# Reset Source and Stabilization Sequencer

This block decides how long a microcontroller core is held in reset after a reset request. It sees four kinds of request: power-up, the external reset pin, a software request and a watchdog request. For each one it looks at the clock state at that moment and at a static option that says whether power-up reset is present. From these it picks a fixed short reset, a full main-oscillator stabilization wait, or a hold that lasts as long as the external pin is asserted. Whichever path it takes, the core always restarts in normal main-clock mode, and the block gives a one-cycle indication of that restart.

The block can also drive an active-low reset pin during the timed phases, when the pin option is set. A cause register keeps the source of the last accepted reset, and reading it clears it. The power-up request `por` resets the block's own state asynchronously. The stabilization length and the short reset length are parameters: `STAB_CYC` (default 16384 cycles) and `SHORT_CYC` (default 4 cycles).

Top module: `rst_seq`

## Requirements
- R1: While `por` is high, `core_rst` is 1 and `rst_cause` is 4'b0001. After `por` falls, there is one more reset cycle. If `por_opt`=1, a `STAB_CYC`-cycle stabilization phase follows before release.
- R2: With `por_opt`=0, releasing `por` gives no stabilization phase. Reset ends after the single extra cycle, unless the pin is still low, in which case reset holds until the pin goes high.
- R3: A software or watchdog request taken in main-clock mode (`clk_mode`=2'b00) holds `core_rst` for exactly `SHORT_CYC` cycles.
- R4: A software or watchdog request taken in subclock (2'b01), stop (2'b10) or stabilizing (2'b11) mode holds `core_rst` for exactly `STAB_CYC` cycles. This happens whatever `por_opt` is.
- R5: With `por_opt`=1, a falling edge on `ext_rst_n` outside main-clock mode first runs `STAB_CYC` stabilization cycles. Reset then continues until the pin is high.
- R6: An external reset in main-clock mode, or any external reset with `por_opt`=0, holds `core_rst` while the pin is low. Reset ends in the cycle after the pin is seen high, with no stabilization phase.
- R7: Any request accepted during a stabilization phase restarts it, so the phase runs a full `STAB_CYC` cycles from that request.
- R8: Requests that arrive together are ranked external, then watchdog, then software. Only the highest-ranked one picks the sequence and the cause. Requests are ignored while reset is held for the external pin.
- R9: `rst_cause` is one-hot, with bit0 power-up, bit1 external, bit2 watchdog and bit3 software. It shows the last accepted source. A `stat_rd` cycle clears it, but a request accepted in the same cycle wins over the clear.
- R10: `restart_main` is high for exactly one cycle: the first cycle in which `core_rst` is low after a reset.
- R11: `rst_pin_n` is low only when `pin_opt`=1 and the block is in a stabilization phase or a short reset. It is never low while reset is held only for the pin, or during the power-up cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por | input | 1 | Power-up reset request, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| sw_req | input | 1 | Software reset request |
| wdt_req | input | 1 | Watchdog reset request |
| clk_mode | input | 2 | Clock state: 00 main, 01 subclock, 10 stop, 11 stabilizing |
| por_opt | input | 1 | Power-up reset present (enables stabilization for power-up and pin resets) |
| pin_opt | input | 1 | Enables the reset output pin |
| stat_rd | input | 1 | Read strobe that clears the cause register |
| core_rst | output | 1 | Internal reset to the core |
| rst_pin_n | output | 1 | Reset output pin, active low |
| restart_main | output | 1 | One-cycle pulse: core restarts in main-clock mode |
| rst_cause | output | 4 | One-hot cause of the last accepted reset |

## Verification
Each source is triggered in main-clock mode and again in subclock or stop mode. The measured reset length then separates the short path from the stabilization path. External resets are held longer than the stabilization phase and also pulsed briefly. This shows where the timed phase ends and where the pin hold begins, and it is run with the power-up option both on and off. Simultaneous requests, a request in the middle of a stabilization phase and a request while the pin holds reset test the ranking, the restart and the ignore rule. Each of these is judged by the reset length and by the cause register.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int STAB_CYC  = 16384,
  parameter int SHORT_CYC = 4
) (
  input  logic       clk,
  input  logic       por,
  input  logic       ext_rst_n,
  input  logic       sw_req,
  input  logic       wdt_req,
  input  logic [1:0] clk_mode,
  input  logic       por_opt,
  input  logic       pin_opt,
  input  logic       stat_rd,
  output logic       core_rst,
  output logic       rst_pin_n,
  output logic       restart_main,
  output logic [3:0] rst_cause
);
  localparam int MAXC = (STAB_CYC > SHORT_CYC) ? STAB_CYC : SHORT_CYC;
  localparam int CW = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] STAB_LAST  = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

  typedef enum logic [2:0] {IDLE, PWR, STAB, SHORT, HOLD} st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic ext_prev;
  logic [3:0] src;

  wire ext_act = ~ext_rst_n;
  wire ext_new = ext_act & ~ext_prev;
  wire in_main = (clk_mode == 2'b00);
  wire open_st = (st == IDLE) || (st == STAB) || (st == SHORT);
  wire accept  = open_st && (ext_new || wdt_req || sw_req);

  always_comb begin
    if (ext_new)      src = 4'b0010;
    else if (wdt_req) src = 4'b0100;
    else              src = 4'b1000;
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt + 1'b1;
    case (st)
      PWR: begin
        cnt_nx = '0;
        st_nx  = por_opt ? STAB : (ext_act ? HOLD : IDLE);
      end
      STAB:
        if (cnt == STAB_LAST) begin
          cnt_nx = '0;
          st_nx  = ext_act ? HOLD : IDLE;
        end
      SHORT:
        if (cnt == SHORT_LAST) begin
          cnt_nx = '0;
          st_nx  = IDLE;
        end
      HOLD: begin
        cnt_nx = '0;
        if (!ext_act) st_nx = IDLE;
      end
      default: cnt_nx = '0;
    endcase
    if (accept) begin
      cnt_nx = '0;
      if (st == STAB)   st_nx = STAB;
      else if (ext_new) st_nx = (por_opt && !in_main) ? STAB : HOLD;
      else              st_nx = in_main ? SHORT : STAB;
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      st           <= PWR;
      cnt          <= '0;
      ext_prev     <= 1'b0;
      restart_main <= 1'b0;
      rst_cause    <= 4'b0001;
    end else begin
      st           <= st_nx;
      cnt          <= cnt_nx;
      ext_prev     <= ext_act;
      restart_main <= (st != IDLE) && (st_nx == IDLE);
      if (accept)       rst_cause <= src;
      else if (stat_rd) rst_cause <= 4'b0000;
    end
  end

  assign core_rst  = (st != IDLE);
  assign rst_pin_n = ~(pin_opt && ((st == STAB) || (st == SHORT)));
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       por,
  input logic       ext_rst_n,
  input logic       sw_req,
  input logic       wdt_req,
  input logic [1:0] clk_mode,
  input logic       pin_opt,
  input logic       stat_rd,
  input logic       core_rst,
  input logic       rst_pin_n,
  input logic       restart_main,
  input logic [3:0] rst_cause
);
  // R9
  cause_onehot_chk: assert property (@(posedge clk) disable iff (por)
    $onehot0(rst_cause));

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (por)
    (!core_rst && stat_rd && !sw_req && !wdt_req && ext_rst_n) |=> (rst_cause == 4'b0000));

  // R10
  restart_after_rst_chk: assert property (@(posedge clk) disable iff (por)
    restart_main |-> (!core_rst && $past(core_rst)));

  // R11
  pin_gated_chk: assert property (@(posedge clk) disable iff (por)
    !pin_opt |-> rst_pin_n);

  // R11
  pin_within_rst_chk: assert property (@(posedge clk) disable iff (por)
    !rst_pin_n |-> core_rst);

  // R3
  sw_main_starts_chk: assert property (@(posedge clk) disable iff (por)
    (!core_rst && sw_req && !wdt_req && ext_rst_n && clk_mode == 2'b00) |=> core_rst);
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .sw_req(sw_req), .wdt_req(wdt_req),
  .clk_mode(clk_mode), .pin_opt(pin_opt), .stat_rd(stat_rd), .core_rst(core_rst),
  .rst_pin_n(rst_pin_n), .restart_main(restart_main), .rst_cause(rst_cause)
);

// File: tb/tb_rst_seq.sv
module tb_rst_seq;
  localparam int PER = 10;
  localparam int ST  = 20;
  localparam int SH  = 4;

  logic clk = 1'b0;
  logic por = 1'b1, ext_rst_n = 1'b1, sw_req = 1'b0, wdt_req = 1'b0;
  logic [1:0] clk_mode = 2'b00;
  logic por_opt = 1'b1, pin_opt = 1'b1, stat_rd = 1'b0;
  logic core_rst, rst_pin_n, restart_main;
  logic [3:0] rst_cause;
  int n_chk = 0, n_fail = 0;

  always #(PER/2) clk = ~clk;

  rst_seq #(.STAB_CYC(ST), .SHORT_CYC(SH)) dut (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .sw_req(sw_req), .wdt_req(wdt_req),
    .clk_mode(clk_mode), .por_opt(por_opt), .pin_opt(pin_opt), .stat_rd(stat_rd),
    .core_rst(core_rst), .rst_pin_n(rst_pin_n), .restart_main(restart_main),
    .rst_cause(rst_cause)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int lo, output int pulse);
    hi = 0; lo = 0; pulse = 0;
    for (int i = 0; i < 1000; i++) begin
      if (!core_rst) begin
        pulse = restart_main;
        break;
      end
      hi++;
      if (!rst_pin_n) lo++;
      @(negedge clk);
    end
  endtask

  task automatic t_por(input logic opt);
    int hi, lo, p;
    por = 1'b1; por_opt = opt;
    @(negedge clk);
    check("R1 core_rst during por", core_rst, 1);
    check("R1 cause during por", rst_cause, 4'b0001);
    check("R11 pin during por", rst_pin_n, 1);
    por = 1'b0;
    measure(hi, lo, p);
    check(opt ? "R1 por length" : "R2 por length", hi, opt ? ST + 1 : 1);
    check(opt ? "R1 por pin low" : "R2 por pin low", lo, opt ? ST : 0);
    check("R10 restart pulse", p, 1);
    @(negedge clk);
    check("R10 pulse one cycle", restart_main, 0);
  endtask

  task automatic t_soft(input logic wd, input logic [1:0] md, input logic pen, input int exp_len);
    int hi, lo, p;
    clk_mode = md; pin_opt = pen;
    if (wd) wdt_req = 1'b1; else sw_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0; sw_req = 1'b0;
    check("R9 cause soft", rst_cause, wd ? 4'b0100 : 4'b1000);
    measure(hi, lo, p);
    check(md == 2'b00 ? "R3 short length" : "R4 stab length", hi, exp_len);
    check("R11 pin low count", lo, pen ? exp_len : 0);
    check("R10 restart pulse", p, 1);
    @(negedge clk);
    pin_opt = 1'b1; clk_mode = 2'b00;
  endtask

  task automatic t_ext_hold(input logic [1:0] md, input logic opt, input int hold, input int exp_lo);
    int lo = 0, hi = 0;
    clk_mode = md; por_opt = opt;
    ext_rst_n = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (core_rst) hi++;
      if (!rst_pin_n) lo++;
    end
    check(exp_lo > 0 ? "R5 held during pin" : "R6 held during pin", hi, hold);
    check(exp_lo > 0 ? "R5 stab pin low" : "R6 no stab", lo, exp_lo);
    check("R9 cause ext", rst_cause, 4'b0010);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check(exp_lo > 0 ? "R5 release after pin" : "R6 release after pin", core_rst, 0);
    check("R10 restart on ext", restart_main, 1);
    @(negedge clk);
    clk_mode = 2'b00; por_opt = 1'b1;
  endtask

  task automatic t_ext_short_pulse();
    int hi, lo, p;
    clk_mode = 2'b10; por_opt = 1'b1;
    ext_rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ext_rst_n = 1'b1;
    hi = 2;
    measure(hi, lo, p);
    check("R5 short pin pulse length", hi + 1, ST);
    @(negedge clk);
    clk_mode = 2'b00;
  endtask

  task automatic t_restart();
    int hi, lo, p;
    clk_mode = 2'b01;
    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    repeat (9) @(negedge clk);
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    check("R9 cause after restart", rst_cause, 4'b1000);
    measure(hi, lo, p);
    check("R7 restarted stab length", hi, ST);
    @(negedge clk);
    clk_mode = 2'b00;
  endtask

  task automatic t_priority();
    int hi, lo, p;
    wdt_req = 1'b1; sw_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0; sw_req = 1'b0;
    check("R8 wdt over sw cause", rst_cause, 4'b0100);
    measure(hi, lo, p);
    check("R8 wdt over sw length", hi, SH);
    @(negedge clk);
    ext_rst_n = 1'b0; wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    check("R8 ext over wdt cause", rst_cause, 4'b0010);
    repeat (SH + 3) @(negedge clk);
    check("R8 ext holds past short", core_rst, 1);
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    check("R8 ignored during pin hold", rst_cause, 4'b0010);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check("R8 release after pin", core_rst, 0);
    @(negedge clk);
  endtask

  task automatic t_status();
    int hi, lo, p;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R9 read clears", rst_cause, 0);
    stat_rd = 1'b1; sw_req = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; sw_req = 1'b0;
    check("R9 set wins over clear", rst_cause, 4'b1000);
    measure(hi, lo, p);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state core_rst", core_rst, 1);
    check("R1 reset state cause", rst_cause, 4'b0001);
    check("R10 reset state restart", restart_main, 0);
    t_por(1'b1);
    t_por(1'b0);
    t_soft(1'b0, 2'b00, 1'b1, SH);
    t_soft(1'b1, 2'b00, 1'b0, SH);
    t_soft(1'b1, 2'b01, 1'b1, ST);
    t_soft(1'b0, 2'b11, 1'b1, ST);
    por_opt = 1'b0;
    t_soft(1'b0, 2'b10, 1'b1, ST);
    por_opt = 1'b1;
    t_ext_hold(2'b01, 1'b1, 30, ST);
    t_ext_hold(2'b00, 1'b1, 7, 0);
    t_ext_hold(2'b10, 1'b0, 10, 0);
    t_ext_short_pulse();
    t_restart();
    t_priority();
    t_status();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PER * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule